// File: doc/BRIEF.md
# Staggered Wavefront Issue Scheduler

This block sequences instruction issue for one compute unit that holds four independent SIMD units, each 16 lanes wide. Work is resident as wavefronts of 64 elements. Every wavefront is tied to one SIMD, which needs four consecutive cycles, one lane group of 16 elements per cycle, to run one instruction for it. The issue port can reach only one SIMD per cycle. It points at SIMD 0, 1, 2 and 3 in turn, so the four units start on consecutive cycles, 0 to 3 cycles apart, and from then on each is fed without a gap.

A one-cycle `start` pulse loads the number of resident wavefronts and one instruction count per wavefront. The instructions of a wavefront depend on each other: the next one may issue as soon as the four-group pass of the previous one has ended. Each lane group gives a result strobe four cycles after its pass cycle. The block raises a per-wavefront finish pulse when the last result of that wavefront appears, and a `done` pulse once all work has drained. Only the timing of lane activity is modelled. No data is computed.

Top module: `wave_issue_sched`

## Requirements
- R1: While reset is held, and after it is released with no start, `simdBusy`, `resultValid`, `waveFin` and `done` are all zero.
- R2: Wavefront w is bound to SIMD (w mod 4), in slot (w div 4) of that SIMD. Once an instruction issues, that SIMD shows `simdBusy` high for four consecutive cycles, and its 2-bit `laneGroup` field (bits 2s+1:2s for SIMD s) reads 0, 1, 2, 3 in that order.
- R3: Cycle 0 is the cycle that follows the clock edge that samples `start`. The issue pointer visits SIMD (c mod 4) in cycle c. A SIMD with work first shows `simdBusy` in cycle s+1, and no two SIMDs begin a pass in the same cycle.
- R4: A SIMD whose wavefronts hold T instructions in total stays busy for exactly 4·T cycles in one unbroken run.
- R5: `resultValid[s]` is high exactly four cycles after each cycle in which SIMD s is busy.
- R6: A SIMD that holds two wavefronts with work left alternates between them on each issue, starting with slot 0. Once one of them has run out, the other issues on consecutive passes.
- R7: `waveFin[w]` pulses for one cycle, in the cycle in which the last result strobe of the last instruction of wavefront w appears. For the j-th issue (counted from 0) of SIMD s, that is cycle s+4j+8.
- R8: `done` is a single-cycle pulse in cycle max over s of (s+4·T_s+4), taken over the SIMDs with T_s>0. With four wavefronts of one instruction this is cycle 11. With eight wavefronts of one instruction it is cycle 15. With four wavefronts of four instructions it is cycle 23.
- R9: Wavefronts with an index at or above `waveCount` are ignored, whatever their count. A `waveCount` above 8 is treated as 8.
- R10: A wavefront with an instruction count of zero is skipped and never pulses `waveFin`. If there is no work at all, `done` pulses in cycle 0.
- R11: A `start` pulse that arrives while a run is in progress has no effect on the timing of that run, and it produces no second `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run, sampled only while idle |
| waveCount | input | 4 | Number of resident wavefronts |
| instrCount | input | 64 | Instruction count of each wavefront, 8 bits each, wavefront w in bits 8w+7:8w |
| simdBusy | output | 4 | SIMD is streaming a lane group this cycle |
| laneGroup | output | 8 | Current lane-group index of each SIMD, 2 bits each |
| resultValid | output | 4 | Result strobe of each SIMD |
| waveFin | output | 8 | Last result of a wavefront is out |
| done | output | 1 | All work of the run has drained |

## Verification
Suppose the issue pointer, a pending count or a slot-alternation bit holds a wrong value. The error first shows as a SIMD whose first busy cycle is wrong, or a busy run that breaks up or has the wrong length. It becomes visible within four cycles of the bad issue. A fault in the latency pipeline moves `resultValid` and `waveFin` away from the busy cycles by a fixed offset, and it is visible eight cycles after the issue at the latest. Any of these faults also moves `done` away from the closed-form cycle. The bench compares every wavefront's finish cycle and the `done` cycle against a model of the alternation that is worked out from the requirements.

// File: rtl/wave_issue_pkg.sv
package wave_issue_pkg;
  // Geometry of the compute unit
  parameter int SIMD_COUNT     = 4;
  parameter int LANES          = 16;
  parameter int WAVE_SIZE      = 64;
  parameter int WAVES_PER_SIMD = 2;

  localparam int GROUPS    = WAVE_SIZE / LANES;
  localparam int GRP_W     = (GROUPS > 1) ? $clog2(GROUPS) : 1;
  localparam int NUM_WAVES = SIMD_COUNT * WAVES_PER_SIMD;
  localparam int SIMD_W    = (SIMD_COUNT > 1) ? $clog2(SIMD_COUNT) : 1;
  localparam int SLOT_W    = (WAVES_PER_SIMD > 1) ? $clog2(WAVES_PER_SIMD) : 1;
  localparam int WC_W      = $clog2(NUM_WAVES + 1);

  // Strobes from the control to the lane datapath, one set per cycle
  typedef struct packed {
    logic [SIMD_COUNT-1:0]             issue;
    logic [SIMD_COUNT-1:0][SLOT_W-1:0] slot;
    logic [SIMD_COUNT-1:0]             lastInstr;
  } issueStrobe_t;

  // One stage of the result latency pipe
  typedef struct packed {
    logic              v;
    logic              fin;
    logic [SLOT_W-1:0] slot;
  } resStage_t;
endpackage

// File: rtl/wave_issue_ctrl.sv
module wave_issue_ctrl
  import wave_issue_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       start,
  input  logic [WC_W-1:0]            waveCount,
  input  logic [NUM_WAVES*CNT_W-1:0] instrCount,
  input  logic [SIMD_COUNT-1:0]      simdFree,
  input  logic                       drainBusy,
  output issueStrobe_t               strobe,
  output logic                       done
);
  logic                  running;
  logic [SIMD_W-1:0]     ptr;
  logic [CNT_W-1:0]      pend     [NUM_WAVES];
  logic [SLOT_W-1:0]     lastSlot [SIMD_COUNT];
  logic [SLOT_W-1:0]     pick     [SIMD_COUNT];
  logic [SIMD_COUNT-1:0] hasWork;
  logic                  anyPend;
  int                    wcEff;

  assign wcEff = (int'(waveCount) > NUM_WAVES) ? NUM_WAVES : int'(waveCount);

  // Choose, per SIMD, the next slot after the last issued one that has work
  always_comb begin
    for (int s = 0; s < SIMD_COUNT; s++) begin
      pick[s]    = '0;
      hasWork[s] = 1'b0;
      for (int k = 1; k <= WAVES_PER_SIMD; k++) begin
        int idx;
        idx = (int'(lastSlot[s]) + k) % WAVES_PER_SIMD;
        if (!hasWork[s] && pend[idx*SIMD_COUNT + s] != '0) begin
          hasWork[s] = 1'b1;
          pick[s]    = SLOT_W'(idx);
        end
      end
    end
  end

  always_comb begin
    anyPend = 1'b0;
    for (int w = 0; w < NUM_WAVES; w++) anyPend = anyPend | (pend[w] != '0);
  end

  // One issue per cycle, to the SIMD the pointer names
  always_comb begin
    strobe = '0;
    for (int s = 0; s < SIMD_COUNT; s++) begin
      strobe.slot[s] = pick[s];
      strobe.issue[s] = running && (ptr == SIMD_W'(s)) && simdFree[s] && hasWork[s];
      strobe.lastInstr[s] = (pend[int'(pick[s])*SIMD_COUNT + s] == CNT_W'(1));
    end
  end

  assign done = running && !anyPend && !drainBusy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      ptr     <= '0;
      for (int w = 0; w < NUM_WAVES; w++) pend[w] <= '0;
      for (int s = 0; s < SIMD_COUNT; s++) lastSlot[s] <= SLOT_W'(WAVES_PER_SIMD - 1);
    end else if (!running) begin
      if (start) begin
        running <= 1'b1;
        ptr     <= '0;
        for (int w = 0; w < NUM_WAVES; w++)
          pend[w] <= (w < wcEff) ? instrCount[w*CNT_W +: CNT_W] : '0;
        for (int s = 0; s < SIMD_COUNT; s++) lastSlot[s] <= SLOT_W'(WAVES_PER_SIMD - 1);
      end
    end else begin
      if (done) running <= 1'b0;
      ptr <= (int'(ptr) == SIMD_COUNT - 1) ? '0 : ptr + 1'b1;
      for (int s = 0; s < SIMD_COUNT; s++) begin
        if (strobe.issue[s]) begin
          pend[int'(pick[s])*SIMD_COUNT + s] <= pend[int'(pick[s])*SIMD_COUNT + s] - 1'b1;
          lastSlot[s] <= pick[s];
        end
      end
    end
  end
endmodule

// File: rtl/wave_lane_datapath.sv
module wave_lane_datapath
  import wave_issue_pkg::*;
#(
  parameter int LAT = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  issueStrobe_t                strobe,
  output logic [SIMD_COUNT-1:0]       simdFree,
  output logic                        drainBusy,
  output logic [SIMD_COUNT-1:0]       simdBusy,
  output logic [SIMD_COUNT*GRP_W-1:0] laneGroup,
  output logic [SIMD_COUNT-1:0]       resultValid,
  output logic [NUM_WAVES-1:0]        waveFin
);
  logic [SIMD_COUNT-1:0] simdDrain;

  for (genvar s = 0; s < SIMD_COUNT; s++) begin : g_simd
    logic              laneV;
    logic [GRP_W-1:0]  laneG;
    logic [SLOT_W-1:0] laneSlot;
    logic              laneLast;
    logic              lastGroup;
    resStage_t         pipe [LAT];

    assign lastGroup = (laneG == GRP_W'(GROUPS - 1));

    // Lane-group sequencer: one group of lanes per cycle
    always_ff @(posedge clk) begin
      if (!rstN) begin
        laneV    <= 1'b0;
        laneG    <= '0;
        laneSlot <= '0;
        laneLast <= 1'b0;
      end else if (strobe.issue[s]) begin
        laneV    <= 1'b1;
        laneG    <= '0;
        laneSlot <= strobe.slot[s];
        laneLast <= strobe.lastInstr[s];
      end else if (laneV) begin
        if (lastGroup) laneV <= 1'b0;
        else           laneG <= laneG + 1'b1;
      end
    end

    // Execution latency modelled as a shift of valid strobes
    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int k = 0; k < LAT; k++) pipe[k] <= '0;
      end else begin
        pipe[0].v    <= laneV;
        pipe[0].fin  <= laneV && laneLast && lastGroup;
        pipe[0].slot <= laneSlot;
        for (int k = 1; k < LAT; k++) pipe[k] <= pipe[k-1];
      end
    end

    always_comb begin
      simdDrain[s] = laneV;
      for (int k = 0; k < LAT - 1; k++) simdDrain[s] = simdDrain[s] | pipe[k].v;
    end

    assign simdFree[s]                 = !laneV || lastGroup;
    assign simdBusy[s]                 = laneV;
    assign laneGroup[s*GRP_W +: GRP_W] = laneV ? laneG : '0;
    assign resultValid[s]              = pipe[LAT-1].v;

    for (genvar k = 0; k < WAVES_PER_SIMD; k++) begin : g_fin
      assign waveFin[k*SIMD_COUNT + s] =
        pipe[LAT-1].v && pipe[LAT-1].fin && (pipe[LAT-1].slot == SLOT_W'(k));
    end
  end

  assign drainBusy = |simdDrain;
endmodule

// File: rtl/wave_issue_sched.sv
module wave_issue_sched
  import wave_issue_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int LAT   = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        start,
  input  logic [WC_W-1:0]             waveCount,
  input  logic [NUM_WAVES*CNT_W-1:0]  instrCount,
  output logic [SIMD_COUNT-1:0]       simdBusy,
  output logic [SIMD_COUNT*GRP_W-1:0] laneGroup,
  output logic [SIMD_COUNT-1:0]       resultValid,
  output logic [NUM_WAVES-1:0]        waveFin,
  output logic                        done
);
  issueStrobe_t          strobe;
  logic [SIMD_COUNT-1:0] simdFree;
  logic                  drainBusy;

  wave_issue_ctrl #(.CNT_W(CNT_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .waveCount(waveCount),
    .instrCount(instrCount), .simdFree(simdFree), .drainBusy(drainBusy),
    .strobe(strobe), .done(done)
  );

  wave_lane_datapath #(.LAT(LAT)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .simdFree(simdFree),
    .drainBusy(drainBusy), .simdBusy(simdBusy), .laneGroup(laneGroup),
    .resultValid(resultValid), .waveFin(waveFin)
  );
endmodule

// File: rtl/wave_issue_sched_chk.sv
module wave_issue_sched_chk
  import wave_issue_pkg::*;
(
  input logic                        clk,
  input logic                        rstN,
  input logic [SIMD_COUNT-1:0]       simdBusy,
  input logic [SIMD_COUNT*GRP_W-1:0] laneGroup,
  input logic [SIMD_COUNT-1:0]       resultValid,
  input logic [NUM_WAVES-1:0]        waveFin,
  input logic                        done
);
  logic [SIMD_COUNT-1:0] passStart;

  always_comb
    for (int s = 0; s < SIMD_COUNT; s++)
      passStart[s] = simdBusy[s] && (laneGroup[s*GRP_W +: GRP_W] == '0);

  AST_ONE_PASS_START: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(passStart)); // R3

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R8

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (simdBusy == '0)); // R8

  for (genvar s = 0; s < SIMD_COUNT; s++) begin : g_s
    AST_GROUP_STEP: assert property (@(posedge clk) disable iff (!rstN)
      (simdBusy[s] && laneGroup[s*GRP_W +: GRP_W] != GRP_W'(GROUPS - 1)) |=>
      (simdBusy[s] && laneGroup[s*GRP_W +: GRP_W] == $past(laneGroup[s*GRP_W +: GRP_W]) + 1'b1)); // R2

    AST_GROUP_FIRST: assert property (@(posedge clk) disable iff (!rstN)
      $rose(simdBusy[s]) |-> (laneGroup[s*GRP_W +: GRP_W] == '0)); // R2
  end

  for (genvar w = 0; w < NUM_WAVES; w++) begin : g_w
    AST_FIN_WITH_RESULT: assert property (@(posedge clk) disable iff (!rstN)
      waveFin[w] |-> resultValid[w % SIMD_COUNT]); // R7
  end
endmodule

bind wave_issue_sched wave_issue_sched_chk i_chk (
  .clk(clk), .rstN(rstN), .simdBusy(simdBusy), .laneGroup(laneGroup),
  .resultValid(resultValid), .waveFin(waveFin), .done(done)
);

// File: tb/test_wave_issue_sched.sv
module test_wave_issue_sched;
  localparam int NW  = 8;
  localparam int NS  = 4;
  localparam int CW  = 8;
  localparam int WIN = 60;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [3:0]    waveCount = '0;
  logic [NW*CW-1:0] instrCount = '0;
  logic [NS-1:0] simdBusy;
  logic [2*NS-1:0] laneGroup;
  logic [NS-1:0] resultValid;
  logic [NW-1:0] waveFin;
  logic          done;

  always #10 clk = ~clk;

  wave_issue_sched i_wave_issue_sched (
    .clk(clk), .rstN(rstN), .start(start), .waveCount(waveCount),
    .instrCount(instrCount), .simdBusy(simdBusy), .laneGroup(laneGroup),
    .resultValid(resultValid), .waveFin(waveFin), .done(done)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  // waveCount, eight instruction counts, expected done cycle
  localparam int VEC [8][10] = '{
    '{4,  1,1,1,1, 0,0,0,0, 11},
    '{8,  1,1,1,1, 1,1,1,1, 15},
    '{4,  4,4,4,4, 0,0,0,0, 23},
    '{2,  3,1,0,0, 0,0,0,0, 16},
    '{8,  1,2,3,4, 5,1,1,2, 31},
    '{3,  0,0,2,5, 0,0,0,0, 14},
    '{15, 1,1,1,1, 1,1,1,1, 15},
    '{0,  3,3,3,3, 3,3,3,3, 0}
  };

  int doneFirst, doneCnt;
  int finFirst [NW];
  int finCnt   [NW];
  int busyCnt  [NS];
  int firstBusy[NS];
  int grpLog0  [WIN];
  int busyLog0 [WIN];
  int resLog0  [WIN];
  int expFin   [NW];
  int expBusy  [NS];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Model of the alternation, built from R3, R6, R7
  task automatic model(input int wc, input int cnt[NW]);
    int eff;
    eff = (wc > NW) ? NW : wc;
    for (int w = 0; w < NW; w++) expFin[w] = -1;
    for (int s = 0; s < NS; s++) begin
      int rem[2];
      int last, j;
      last = 1; j = 0;
      for (int k = 0; k < 2; k++) rem[k] = (k*NS + s < eff) ? cnt[k*NS + s] : 0;
      expBusy[s] = 4 * (rem[0] + rem[1]);
      while (rem[0] + rem[1] > 0) begin
        int p;
        p = (rem[(last + 1) % 2] > 0) ? (last + 1) % 2 : last;
        rem[p]--;
        if (rem[p] == 0) expFin[p*NS + s] = s + 4*j + 8;
        last = p;
        j++;
      end
    end
  endtask

  task automatic runVec(input int wc, input int cnt[NW], input int extraStart);
    waveCount = 4'(wc);
    for (int w = 0; w < NW; w++) instrCount[w*CW +: CW] = CW'(cnt[w]);
    doneFirst = -1; doneCnt = 0;
    for (int w = 0; w < NW; w++) begin finFirst[w] = -1; finCnt[w] = 0; end
    for (int s = 0; s < NS; s++) begin busyCnt[s] = 0; firstBusy[s] = -1; end
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < WIN; c++) begin
      if (done) begin doneCnt++; if (doneFirst < 0) doneFirst = c; end
      for (int w = 0; w < NW; w++)
        if (waveFin[w]) begin finCnt[w]++; if (finFirst[w] < 0) finFirst[w] = c; end
      for (int s = 0; s < NS; s++)
        if (simdBusy[s]) begin busyCnt[s]++; if (firstBusy[s] < 0) firstBusy[s] = c; end
      grpLog0[c]  = int'(laneGroup[1:0]);
      busyLog0[c] = int'(simdBusy[0]);
      resLog0[c]  = int'(resultValid[0]);
      start = (c == extraStart);
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int cnt[NW];
    repeat (3) @(negedge clk);
    // R1: reset state
    check(simdBusy == '0 && resultValid == '0 && waveFin == '0 && !done, "R1 in reset",
          int'({simdBusy, resultValid, waveFin, done}), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(simdBusy == '0 && resultValid == '0 && waveFin == '0 && !done, "R1 idle after reset",
          int'({simdBusy, resultValid, waveFin, done}), 0);

    // Table walk
    for (int v = 0; v < 8; v++) begin
      for (int w = 0; w < NW; w++) cnt[w] = VEC[v][w+1];
      model(VEC[v][0], cnt);
      runVec(VEC[v][0], cnt, -1);
      check(doneFirst == VEC[v][9], "R8/R9/R10 done cycle", doneFirst, VEC[v][9]);
      check(doneCnt == 1, "R8 single done pulse", doneCnt, 1);
      for (int w = 0; w < NW; w++) begin
        check(finFirst[w] == expFin[w], "R6/R7/R10 waveFin cycle", finFirst[w], expFin[w]);
        check(finCnt[w] == ((expFin[w] < 0) ? 0 : 1), "R7 waveFin pulse count",
              finCnt[w], (expFin[w] < 0) ? 0 : 1);
      end
      for (int s = 0; s < NS; s++) begin
        check(busyCnt[s] == expBusy[s], "R4 busy cycles", busyCnt[s], expBusy[s]);
        check(firstBusy[s] == ((expBusy[s] > 0) ? s + 1 : -1), "R3 first busy cycle",
              firstBusy[s], (expBusy[s] > 0) ? s + 1 : -1);
      end
      repeat (2) @(negedge clk);
    end

    // R2 and R5: single wavefront, single instruction on SIMD 0
    for (int w = 0; w < NW; w++) cnt[w] = 0;
    cnt[0] = 1;
    runVec(1, cnt, -1);
    for (int c = 1; c <= 4; c++) begin
      check(busyLog0[c] == 1, "R2 busy during pass", busyLog0[c], 1);
      check(grpLog0[c] == c - 1, "R2 lane group order", grpLog0[c], c - 1);
    end
    check(busyLog0[0] == 0 && busyLog0[5] == 0, "R2 pass is four cycles",
          busyLog0[0] + busyLog0[5], 0);
    for (int c = 0; c < 12; c++)
      check(resLog0[c] == ((c >= 5 && c <= 8) ? 1 : 0), "R5 result strobe delay",
            resLog0[c], (c >= 5 && c <= 8) ? 1 : 0);
    repeat (2) @(negedge clk);

    // R11: start while running is ignored
    for (int w = 0; w < NW; w++) cnt[w] = (w < 4) ? 1 : 0;
    runVec(4, cnt, 5);
    check(doneFirst == 11, "R11 done unchanged by late start", doneFirst, 11);
    check(doneCnt == 1, "R11 no second run", doneCnt, 1);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule